// File: doc/BRIEF.md
# Jitter Buffer Address Controller

The block sits between a symbol demodulator running at disc rate and a consumer running at crystal rate. Incoming 8-bit symbols are stored in a circular array organised as frames of 32 symbols. The write side advances on each write strobe and the read side advances on each read strobe. At every read-frame boundary the block measures how far the write frame has drifted from its nominal position half a buffer ahead of the read frame.

It turns that drift into one of three frame-period division ratios for the spindle speed loop. The ratio is raised when the writer lags and lowered when it leads, so the loop pulls the drift back to zero. When the drift reaches four frames in either direction, the block moves the write position back to the nominal distance. It then raises a mute request for a fixed number of read frames so that the glitch is not heard.

Top module: `jb_addr_ctl`

## Requirements
- R1: After reset `ratio_o` is 588 and `mute_o` is 0. The read position is frame 0, symbol 0, and the write position is frame 32 (half of the 64-frame array), symbol 0, so the drift starts at 0.
- R2: The array holds 2048 symbols of 8 bits. A read strobe returns the stored symbol on `rd_data_o` in the cycle after the strobe. When writes and reads run in lockstep from reset, read number n returns write number n-1024.
- R3: Drift is measured only on a read strobe that consumes symbol 31 of a frame. It is (write frame − read frame − 32) modulo 64, read as a signed 6-bit value. Both pointers are taken as they stand after that cycle's strobes.
- R4: A drift of 0 sets `ratio_o` to 588.
- R5: A drift of −1 to −3 sets `ratio_o` to 589.
- R6: A drift of +1 to +3 sets `ratio_o` to 587.
- R7: A drift of ≥ +4 or ≤ −4 moves the write position to (new read frame + 32), symbol 0, which makes the drift 0 again. It also sets `ratio_o` to 588.
- R8: Each re-center asserts `mute_o`, which stays high for 128 further read-frame boundaries. A re-center that occurs while the mute is already high restarts the full 128-frame count.
- R9: `ratio_o` changes only on a read-frame boundary. Write strobes and reads of symbols 0 to 30 leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe; stores `wr_data_i` and advances the write position |
| wr_data_i | input | 8 | Demodulated symbol |
| rd_en_i | input | 1 | Read strobe; advances the read position |
| rd_data_o | output | 8 | Symbol read by the previous strobe |
| ratio_o | output | 10 | Frame-period division ratio for the speed loop |
| mute_o | output | 1 | Mute request after a forced re-center |

## Verification
A write pointer that is stuck or has been loaded wrongly shows up at the next read-frame boundary, because `ratio_o` then moves to the wrong one of 587/588/589. Read-back data would also come from the wrong frame once the reader reaches it, which is 32 frames later. A drift sign that is flipped is seen after a single unbalanced frame. A mute counter that is off by one, or that does not reload, is only visible at the 128th boundary after a re-center, so those windows are run in full.

// File: rtl/jb_pkg.sv
package jb_pkg;
  typedef enum logic [1:0] {
    OFS_CENTER,
    OFS_BEHIND,
    OFS_AHEAD,
    OFS_LOST
  } ofs_class_e;

  function automatic ofs_class_e ofs_classify(input int ofs, input int lim);
    if (ofs >= lim || ofs <= -lim) return OFS_LOST;
    else if (ofs > 0)              return OFS_AHEAD;
    else if (ofs < 0)              return OFS_BEHIND;
    else                           return OFS_CENTER;
  endfunction
endpackage

// File: rtl/jb_ptr.sv
module jb_ptr #(
  parameter int unsigned          FRAME_AW   = 6,
  parameter int unsigned          SYM_AW     = 5,
  parameter logic [FRAME_AW-1:0]  INIT_FRAME = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic                load_i,
  input  logic [FRAME_AW-1:0] load_frame_i,
  output logic [FRAME_AW-1:0] frame_o,
  output logic [SYM_AW-1:0]   sym_o,
  output logic [FRAME_AW-1:0] adv_frame_o
);
  localparam logic [SYM_AW-1:0] SYM_ONE = SYM_AW'(1);

  logic [FRAME_AW-1:0] frame_q;
  logic [SYM_AW-1:0]   sym_q;
  logic                wrap;

  // frame advances when the last symbol of a frame is stepped over
  assign wrap        = step_i & (&sym_q);
  assign adv_frame_o = frame_q + FRAME_AW'(wrap);
  assign frame_o     = frame_q;
  assign sym_o       = sym_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= INIT_FRAME;
      sym_q   <= '0;
    end else if (load_i) begin
      frame_q <= load_frame_i;
      sym_q   <= '0;
    end else if (step_i) begin
      frame_q <= adv_frame_o;
      sym_q   <= sym_q + SYM_ONE;
    end
  end
endmodule

// File: rtl/jb_store.sv
module jb_store #(
  parameter int unsigned SYM_W   = 8,
  parameter int unsigned DEPTH   = 2048,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [SYM_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [SYM_W-1:0] rd_data_o
);
  logic [SYM_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  generate
    if (OUT_REG) begin : g_reg
      logic [SYM_W-1:0] rd_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      rd_q <= '0;
        else if (rd_en_i) rd_q <= mem[rd_addr_i];
      end
      assign rd_data_o = rd_q;
    end else begin : g_comb
      assign rd_data_o = rd_en_i ? mem[rd_addr_i] : '0;
    end
  endgenerate
endmodule

// File: rtl/jb_offset_ctl.sv
module jb_offset_ctl
  import jb_pkg::*;
#(
  parameter int unsigned FRAME_AW    = 6,
  parameter int unsigned RATIO_W     = 10,
  parameter int          RATIO_NOM   = 588,
  parameter int          LOST_LIM    = 4,
  parameter int unsigned MUTE_FRAMES = 128,
  localparam int unsigned MCW        = $clog2(MUTE_FRAMES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_end_i,
  input  logic [FRAME_AW-1:0] wr_frame_i,
  input  logic [FRAME_AW-1:0] rd_frame_i,
  output logic                recenter_o,
  output logic [RATIO_W-1:0]  ratio_o,
  output logic                mute_o
);
  localparam logic [FRAME_AW-1:0] CENTER = FRAME_AW'((1 << FRAME_AW) / 2);
  localparam logic [RATIO_W-1:0]  R_NOM  = RATIO_W'(RATIO_NOM);
  localparam logic [RATIO_W-1:0]  R_UP   = RATIO_W'(RATIO_NOM + 1);
  localparam logic [RATIO_W-1:0]  R_DN   = RATIO_W'(RATIO_NOM - 1);

  logic signed [FRAME_AW-1:0] ofs;
  ofs_class_e                 cls;
  logic [RATIO_W-1:0]         ratio_q;
  logic [MCW-1:0]             mute_cnt_q;

  // modular distance relative to the nominal half-buffer lead
  assign ofs        = $signed(wr_frame_i - rd_frame_i - CENTER);
  assign cls        = ofs_classify(int'(ofs), LOST_LIM);
  assign recenter_o = frame_end_i && (cls == OFS_LOST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= R_NOM;
    end else if (frame_end_i) begin
      unique case (cls)
        OFS_AHEAD:  ratio_q <= R_DN;
        OFS_BEHIND: ratio_q <= R_UP;
        default:    ratio_q <= R_NOM;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            mute_cnt_q <= '0;
    else if (recenter_o)                    mute_cnt_q <= MCW'(MUTE_FRAMES);
    else if (frame_end_i && mute_cnt_q != '0) mute_cnt_q <= mute_cnt_q - MCW'(1);
  end

  assign ratio_o = ratio_q;
  assign mute_o  = (mute_cnt_q != '0);
endmodule

// File: rtl/jb_addr_ctl.sv
module jb_addr_ctl #(
  parameter int unsigned SYM_W       = 8,
  parameter int unsigned FRAME_SYMS  = 32,
  parameter int unsigned FRAMES      = 64,
  parameter int unsigned RATIO_W     = 10,
  parameter int          RATIO_NOM   = 588,
  parameter int          LOST_LIM    = 4,
  parameter int unsigned MUTE_FRAMES = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [SYM_W-1:0]   wr_data_i,
  input  logic               rd_en_i,
  output logic [SYM_W-1:0]   rd_data_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               mute_o
);
  localparam int unsigned FRAME_AW = $clog2(FRAMES);
  localparam int unsigned SYM_AW   = $clog2(FRAME_SYMS);
  localparam int unsigned DEPTH    = FRAMES * FRAME_SYMS;
  localparam logic [FRAME_AW-1:0] CENTER = FRAME_AW'(FRAMES / 2);

  logic [FRAME_AW-1:0] wr_frame, wr_adv, rd_frame, rd_adv;
  logic [SYM_AW-1:0]   wr_sym, rd_sym;
  logic                frame_end, recenter;

  assign frame_end = rd_en_i & (&rd_sym);

  jb_ptr #(.FRAME_AW(FRAME_AW), .SYM_AW(SYM_AW), .INIT_FRAME(CENTER)) u_wr_ptr (
    .clk_i, .rst_ni,
    .step_i       (wr_en_i),
    .load_i       (recenter),
    .load_frame_i (rd_adv + CENTER),
    .frame_o      (wr_frame),
    .sym_o        (wr_sym),
    .adv_frame_o  (wr_adv)
  );

  jb_ptr #(.FRAME_AW(FRAME_AW), .SYM_AW(SYM_AW), .INIT_FRAME('0)) u_rd_ptr (
    .clk_i, .rst_ni,
    .step_i       (rd_en_i),
    .load_i       (1'b0),
    .load_frame_i ('0),
    .frame_o      (rd_frame),
    .sym_o        (rd_sym),
    .adv_frame_o  (rd_adv)
  );

  jb_store #(.SYM_W(SYM_W), .DEPTH(DEPTH), .OUT_REG(1'b1)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i,
    .wr_addr_i (FRAME_AW'(wr_frame) * FRAME_SYMS[$clog2(DEPTH)-1:0] + $clog2(DEPTH)'(wr_sym)),
    .wr_data_i,
    .rd_en_i,
    .rd_addr_i ({rd_frame, rd_sym}),
    .rd_data_o
  );

  jb_offset_ctl #(
    .FRAME_AW(FRAME_AW), .RATIO_W(RATIO_W), .RATIO_NOM(RATIO_NOM),
    .LOST_LIM(LOST_LIM), .MUTE_FRAMES(MUTE_FRAMES)
  ) u_ctl (
    .clk_i, .rst_ni,
    .frame_end_i (frame_end),
    .wr_frame_i  (wr_adv),
    .rd_frame_i  (rd_adv),
    .recenter_o  (recenter),
    .ratio_o,
    .mute_o
  );
endmodule

// File: rtl/jb_addr_ctl_chk.sv
module jb_addr_ctl_chk #(
  parameter int unsigned RATIO_W     = 10,
  parameter int          RATIO_NOM   = 588,
  parameter int unsigned MUTE_FRAMES = 128
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_end_i,
  input logic               recenter_i,
  input logic [RATIO_W-1:0] ratio_i,
  input logic               mute_i
);
  int unsigned mute_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    mute_seen_q <= 0;
    else if (recenter_i)            mute_seen_q <= 0;
    else if (frame_end_i && mute_i) mute_seen_q <= mute_seen_q + 1;
  end

  // R4
  ratio_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i == RATIO_W'(RATIO_NOM - 1)) || (ratio_i == RATIO_W'(RATIO_NOM)) ||
    (ratio_i == RATIO_W'(RATIO_NOM + 1)));

  // R9
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(ratio_i));

  // R7
  recenter_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recenter_i |=> (ratio_i == RATIO_W'(RATIO_NOM)) && mute_i);

  // R8
  mute_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mute_i) |-> (mute_seen_q == MUTE_FRAMES));
endmodule

bind jb_addr_ctl jb_addr_ctl_chk #(
  .RATIO_W(RATIO_W), .RATIO_NOM(RATIO_NOM), .MUTE_FRAMES(MUTE_FRAMES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_end_i (frame_end),
  .recenter_i  (recenter),
  .ratio_i     (ratio_o),
  .mute_i      (mute_o)
);

// File: tb/sim_jb_addr_ctl.sv
`timescale 1ns/1ps
module sim_jb_addr_ctl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [9:0] ratio_o;
  logic       mute_o;

  int checks = 0;
  int failures = 0;
  int wr_cnt = 0;

  always #2 clk_i = ~clk_i;

  jb_addr_ctl u0 (.*);

  // {write frames, read frames, expected ratio, expected mute}
  localparam int NV = 9;
  localparam int VEC [NV][4] = '{
    '{2, 1, 587, 0}, '{3, 1, 587, 0}, '{0, 3, 588, 0},
    '{0, 2, 589, 0}, '{0, 1, 589, 0}, '{1, 1, 589, 0},
    '{6, 2, 587, 0}, '{4, 1, 588, 1}, '{0, 1, 589, 1}
  };

  function automatic logic [7:0] pat(input int n);
    return 8'((n * 13 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic re);
    wr_en_i = we; rd_en_i = re; wr_data_i = pat(wr_cnt);
    if (we) wr_cnt++;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; rd_en_i = 1'b0;
  endtask

  task automatic frames_w(input int n);
    repeat (n * 32) step(1'b1, 1'b0);
  endtask
  task automatic frames_r(input int n);
    repeat (n * 32) step(1'b0, 1'b1);
  endtask
  task automatic frames_lock(input int n);
    repeat (n * 32) step(1'b1, 1'b1);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(posedge clk_i); #1;
    chk(ratio_o == 10'd588, "R1 reset ratio", ratio_o, 588);
    chk(mute_o == 1'b0, "R1 reset mute", mute_o, 0);
    rst_ni = 1'b1;

    // R2: lockstep read-back, write n returns at read n+1024; R4 holds at 588
    for (int k = 0; k < 33 * 32; k++) begin
      step(1'b1, 1'b1);
      if (k >= 1024) chk(rd_data_o == pat(k - 1024), "R2 read data", rd_data_o, pat(k - 1024));
    end
    chk(ratio_o == 10'd588, "R4 lockstep ratio", ratio_o, 588);
    chk(mute_o == 1'b0, "R4 lockstep mute", mute_o, 0);

    // ratio table: R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      frames_w(VEC[v][0]);
      frames_r(VEC[v][1]);
      chk(ratio_o == 10'(VEC[v][2]), "R5 R6 R7 vector ratio", ratio_o, VEC[v][2]);
      chk(mute_o == 1'(VEC[v][3]), "R7 R8 vector mute", mute_o, VEC[v][3]);
    end

    // R8: 1 boundary used; 126 more keep mute, the 128th clears it
    frames_lock(126);
    chk(mute_o == 1'b1, "R8 mute at 127", mute_o, 1);
    chk(ratio_o == 10'd589, "R5 drift kept at -1", ratio_o, 589);
    frames_lock(1);
    chk(mute_o == 1'b0, "R8 mute after 128", mute_o, 0);

    // R9: writes and partial frames do not move ratio
    frames_w(2);
    chk(ratio_o == 10'd589, "R9 writes only", ratio_o, 589);
    repeat (31) step(1'b0, 1'b1);
    chk(ratio_o == 10'd589, "R9 mid frame", ratio_o, 589);
    step(1'b0, 1'b1);
    chk(ratio_o == 10'd588, "R9 R4 boundary", ratio_o, 588);

    // R7 negative side
    frames_r(3);
    chk(ratio_o == 10'd589, "R5 drift -3", ratio_o, 589);
    chk(mute_o == 1'b0, "R7 no recenter at -3", mute_o, 0);
    frames_r(1);
    chk(ratio_o == 10'd588, "R7 recenter at -4", ratio_o, 588);
    chk(mute_o == 1'b1, "R8 mute after -4", mute_o, 1);

    // R8 reload on a second re-center
    frames_lock(10);
    frames_w(5);
    frames_r(1);
    chk(ratio_o == 10'd588, "R7 recenter at +4", ratio_o, 588);
    frames_lock(127);
    chk(mute_o == 1'b1, "R8 reload keeps mute", mute_o, 1);
    frames_lock(1);
    chk(mute_o == 1'b0, "R8 reload ends", mute_o, 0);

    // R1: reset mid-run, then one unbalanced read frame gives drift -1
    frames_w(2);
    frames_r(1);
    chk(ratio_o == 10'd587, "R6 before reset", ratio_o, 587);
    rst_ni = 1'b0; #1;
    chk(ratio_o == 10'd588, "R1 reset ratio again", ratio_o, 588);
    chk(mute_o == 1'b0, "R1 reset mute again", mute_o, 0);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    frames_r(1);
    chk(ratio_o == 10'd589, "R1 write starts at center", ratio_o, 589);

    finish_run();
  end
endmodule